// File: doc/BRIEF.md
# I2C Clock Phase Generator

This block paces the clock line of an I2C master from a fast system clock. A packed configuration word carries three fields: a power-of-two prescale exponent, a count for the high phase and a count for the low phase. The prescaler turns the system clock into base ticks. The low phase then lasts (low count + 1) base ticks and the high phase lasts (high count + 1) base ticks. The block drives the line as an open-drain pull-down and releases it for the high phase. While the line reads low after release, another device is stretching the clock, and the high phase waits for it.

A bit engine alongside the block uses two single-cycle strobes. The first marks the middle of the low phase, where data may change. The second marks the middle of the high phase, where data is sampled. A combinational helper is also part of the block. It turns a requested total divisor (system clocks per SCL period) into the three configuration fields, so firmware or a neighbouring block can fill the word.

Top module: `scl_timing_gen`

## Requirements
- R1: While reset is asserted, `scl_drive_low`, `strobe_change` and `strobe_sample` are all 0.
- R2: After a clock edge that sees `enable`=1 and `run`=0, the line is released (`scl_drive_low`=0) and no strobe fires. After a clock edge that sees `run`=1 while idle, a new period starts with the low phase.
- R3: The configuration word holds the high count in bits 19:16, the low count in bits 15:12 and the prescale exponent B in bits 3:0; all other bits are ignored. With an unstretched line, the low phase lasts (low+1)·2^B clocks and the high phase lasts (high+1)·2^B clocks.
- R4: Zero high and low counts give one base tick in each phase, so the period is 2·2^B clocks.
- R5: In every low phase, `strobe_change` pulses exactly once, on the first clock of base tick floor((low+1)/2) of that phase (ticks counted from 0). In every high phase, `strobe_sample` pulses exactly once, on the first clock of base tick floor((high+1)/2).
- R6: During the high phase, while `scl_sense` reads 0, the prescaler and the phase counter hold, so the high phase grows by the number of held clocks. `strobe_sample` stays 0 while the line reads low.
- R7: A new configuration word is taken only at the start of a low phase. The period in progress finishes with the old values.
- R8: While `enable` is 0, all state freezes, `scl_drive_low` keeps its value and both strobes are 0. The phase then resumes where it stopped.
- R9: The encoder chooses exponent 0 for a divisor of 33 or less. Above that, it chooses floor(log2((divisor-1)/32)) + 1.
- R10: The encoder divides the divisor by 2^B (rounding down), gives the high part ceil(q/2) and the low part the remainder, and stores each part minus one, limited to 0..15. `div_cfg` places the fields as in R3 and leaves all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Clock enable for all state |
| run | input | 1 | Request to generate clock periods |
| cfg_word | input | CFG_W | Packed timing configuration |
| scl_sense | input | 1 | Sampled level of the SCL line |
| div_req | input | DIV_W | Requested system clocks per SCL period |
| div_cfg | output | CFG_W | Configuration word encoded from `div_req` |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| strobe_change | output | 1 | Middle of the low phase |
| strobe_sample | output | 1 | Middle of the high phase |

## Verification
The hardest case to reach is clock stretching that begins exactly on the sampling point of the high phase. There the strobe must be held off and must fire only once, on the first clock after the line rises. The bench models the line as a wired AND of its own pull-down and the block's pull-down. It counts clocks from the start of the high phase and asserts the pull-down on the very cycle the strobe is due, then on an earlier cycle with a prescaler running. It checks the shifted strobe position and the longer phase. The bench also drops `enable` just before the change point and changes the configuration in mid-period, which shows the freeze and the period-boundary latch.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

  // field geometry of the packed configuration word
  localparam int BASE_W   = 4;
  localparam int FIELD_W  = 4;
  localparam int BASE_LSB = 0;
  localparam int LO_LSB   = 12;
  localparam int HI_LSB   = 16;
  localparam int FIELD_MAX = (1 << FIELD_W) - 1;
  localparam int BASE_MAX  = (1 << BASE_W) - 1;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  typedef struct packed {
    logic [FIELD_W-1:0] hi;
    logic [FIELD_W-1:0] lo;
    logic [BASE_W-1:0]  base;
  } scl_cfg_t;

endpackage

// File: rtl/scl_div_encoder.sv
module scl_div_encoder
  import scl_timing_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int CFG_W = 32
) (
  input  logic [DIV_W-1:0] div_req,
  output logic [CFG_W-1:0] div_cfg
);

  // largest quotient both phases can hold before a prescale step is needed
  localparam int SPAN       = 2 * (FIELD_MAX + 1);
  localparam int SPAN_SHIFT = $clog2(SPAN);

  logic [DIV_W-1:0]   quo_span;
  logic [DIV_W-1:0]   quo_base;
  logic [DIV_W-1:0]   hi_part;
  logic [DIV_W-1:0]   lo_part;
  logic [BASE_W-1:0]  base_sel;
  logic [FIELD_W-1:0] hi_fld;
  logic [FIELD_W-1:0] lo_fld;
  int                 top_bit;

  function automatic logic [FIELD_W-1:0] to_field(input logic [DIV_W-1:0] part);
    if (part == '0)
      return '0;
    else if (part > DIV_W'(FIELD_MAX + 1))
      return FIELD_W'(FIELD_MAX);
    else
      return FIELD_W'(part - DIV_W'(1));
  endfunction

  always_comb begin
    quo_span = (div_req - DIV_W'(1)) >> SPAN_SHIFT;
    top_bit  = 0;
    for (int i = 0; i < DIV_W; i++) begin
      if (quo_span[i]) top_bit = i;
    end
    if (div_req <= DIV_W'(SPAN + 1))
      base_sel = '0;
    else if (top_bit + 1 > BASE_MAX)
      base_sel = BASE_W'(BASE_MAX);
    else
      base_sel = BASE_W'(top_bit + 1);
    quo_base = div_req >> base_sel;
    hi_part  = (quo_base >> 1) + DIV_W'(quo_base[0]);
    lo_part  = quo_base - hi_part;
    hi_fld   = to_field(hi_part);
    lo_fld   = to_field(lo_part);
  end

  always_comb begin
    div_cfg = '0;
    div_cfg[HI_LSB   +: FIELD_W] = hi_fld;
    div_cfg[LO_LSB   +: FIELD_W] = lo_fld;
    div_cfg[BASE_LSB +: BASE_W]  = base_sel;
  end

  // R10
  always_comb begin
    split_order_chk: assert (hi_fld >= lo_fld);
  end

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler
  import scl_timing_pkg::*;
#(
  parameter int EXP_W = BASE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             advance,
  input  logic [EXP_W-1:0] base_exp,
  output logic             tick,
  output logic             at_start
);

  localparam int PRE_W = (1 << EXP_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;
  logic [PRE_W-1:0] wrap_at;

  // an exponent of PRE_W shifts the one out, which wraps to all ones
  assign wrap_at  = (PRE_W'(1) << base_exp) - PRE_W'(1);
  assign tick     = (pre_q == wrap_at);
  assign at_start = (pre_q == '0);

  always_comb begin
    pre_d = pre_q;
    if (restart)
      pre_d = '0;
    else if (advance)
      pre_d = tick ? '0 : pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pre_q <= '0;
    else if (restart || advance)
      pre_q <= pre_d;
  end

  // R3
  presc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !restart && tick) |=> (pre_q == '0));

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_timing_pkg::*;
#(
  parameter int CFG_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              run,
  input  logic              scl_sense,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic              tick,
  input  logic              at_start,
  output logic [BASE_W-1:0] base_exp,
  output logic              presc_advance,
  output logic              presc_restart,
  output logic              scl_drive_low,
  output logic              strobe_change,
  output logic              strobe_sample
);

  phase_e             state_q, state_d;
  logic [FIELD_W-1:0] cnt_q, cnt_d;
  scl_cfg_t           cfg_q, cfg_d;
  scl_cfg_t           cfg_in;
  logic               stretched;
  logic [FIELD_W-1:0] lo_mid;
  logic [FIELD_W-1:0] hi_mid;
  logic [CFG_W-(HI_LSB+FIELD_W)+(LO_LSB-BASE_LSB-BASE_W)-1:0] cfg_unused;

  assign cfg_in.hi   = cfg_word[HI_LSB   +: FIELD_W];
  assign cfg_in.lo   = cfg_word[LO_LSB   +: FIELD_W];
  assign cfg_in.base = cfg_word[BASE_LSB +: BASE_W];
  assign cfg_unused  = {cfg_word[CFG_W-1:HI_LSB+FIELD_W],
                        cfg_word[LO_LSB-1:BASE_LSB+BASE_W]};

  assign stretched = (state_q == PH_HIGH) && !scl_sense;
  assign lo_mid    = FIELD_W'(({1'b0, cfg_q.lo} + 5'd1) >> 1);
  assign hi_mid    = FIELD_W'(({1'b0, cfg_q.hi} + 5'd1) >> 1);

  assign base_exp      = cfg_q.base;
  assign presc_advance = enable && run && (state_q != PH_IDLE) && !stretched;
  assign presc_restart = enable && (!run || (state_q == PH_IDLE));
  assign scl_drive_low = (state_q == PH_LOW);
  assign strobe_change = enable && (state_q == PH_LOW) && at_start && (cnt_q == lo_mid);
  assign strobe_sample = enable && (state_q == PH_HIGH) && scl_sense && at_start
                         && (cnt_q == hi_mid);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cfg_d   = cfg_q;
    if (!run) begin
      state_d = PH_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        PH_IDLE: begin
          state_d = PH_LOW;
          cnt_d   = '0;
          cfg_d   = cfg_in;
        end
        PH_LOW: begin
          if (tick) begin
            if (cnt_q == cfg_q.lo) begin
              state_d = PH_HIGH;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + FIELD_W'(1);
            end
          end
        end
        PH_HIGH: begin
          if (!stretched && tick) begin
            if (cnt_q == cfg_q.hi) begin
              state_d = PH_LOW;
              cnt_d   = '0;
              cfg_d   = cfg_in;
            end else begin
              cnt_d = cnt_q + FIELD_W'(1);
            end
          end
        end
        default: begin
          state_d = PH_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
      cfg_q   <= '0;
    end else if (enable) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      cfg_q   <= cfg_d;
    end
  end

  // R6
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && run && (state_q == PH_HIGH) && !scl_sense) |=> $stable(cnt_q));

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == PH_LOW) && ($past(state_q) == PH_LOW)) |-> $stable(cfg_q));

  // R8
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(scl_drive_low));

  // R5
  sample_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_sample |-> (scl_sense && !scl_drive_low));

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_timing_pkg::*;
#(
  parameter int CFG_W = 32,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             run,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             scl_sense,
  input  logic [DIV_W-1:0] div_req,
  output logic [CFG_W-1:0] div_cfg,
  output logic             scl_drive_low,
  output logic             strobe_change,
  output logic             strobe_sample
);

  logic              tick;
  logic              at_start;
  logic              presc_advance;
  logic              presc_restart;
  logic [BASE_W-1:0] base_exp;

  scl_div_encoder #(.DIV_W(DIV_W), .CFG_W(CFG_W)) u_encoder (
    .div_req (div_req),
    .div_cfg (div_cfg)
  );

  scl_prescaler #(.EXP_W(BASE_W)) u_prescaler (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (presc_restart),
    .advance  (presc_advance),
    .base_exp (base_exp),
    .tick     (tick),
    .at_start (at_start)
  );

  scl_phase_fsm #(.CFG_W(CFG_W)) u_phase (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .run           (run),
    .scl_sense     (scl_sense),
    .cfg_word      (cfg_word),
    .tick          (tick),
    .at_start      (at_start),
    .base_exp      (base_exp),
    .presc_advance (presc_advance),
    .presc_restart (presc_restart),
    .scl_drive_low (scl_drive_low),
    .strobe_change (strobe_change),
    .strobe_sample (strobe_sample)
  );

  // R2
  run_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !run) |=> (!scl_drive_low && !strobe_change && !strobe_sample));

endmodule

// File: tb/scl_timing_gen_bench.sv
module scl_timing_gen_bench;

  localparam int CFG_W = 32;
  localparam int DIV_W = 16;
  localparam time HALF = 10ns;

  logic             clk;
  logic             rst_n;
  logic             enable;
  logic             run;
  logic [CFG_W-1:0] cfg_word;
  logic             scl_sense;
  logic [DIV_W-1:0] div_req;
  logic [CFG_W-1:0] div_cfg;
  logic             scl_drive_low;
  logic             strobe_change;
  logic             strobe_sample;
  logic             ext_low;

  int n_tests = 0;
  int n_fail  = 0;

  // wired-AND line: either side may pull it low
  assign scl_sense = !scl_drive_low && !ext_low;

  scl_timing_gen #(.CFG_W(CFG_W), .DIV_W(DIV_W)) u_scl_timing_gen (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .run           (run),
    .cfg_word      (cfg_word),
    .scl_sense     (scl_sense),
    .div_req       (div_req),
    .div_cfg       (div_cfg),
    .scl_drive_low (scl_drive_low),
    .strobe_change (strobe_change),
    .strobe_sample (strobe_sample)
  );

  initial clk = 1'b0;
  always #HALF clk = ~clk;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [CFG_W-1:0] mk_cfg(input int b, input int hi, input int lo);
    return CFG_W'((hi << 16) | (lo << 12) | b);
  endfunction

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_rise();
    int guard = 0;
    while (scl_drive_low == 1'b1 && guard < 5000) begin step(); guard++; end
    while (scl_drive_low == 1'b0 && guard < 5000) begin step(); guard++; end
  endtask

  // called on the first sample of a low phase; ends on the first sample of the next
  task automatic measure_cur(input int st_at, input int st_len,
                             output int lo_len, output int hi_len,
                             output int chg_off, output int chg_cnt,
                             output int smp_off, output int smp_cnt);
    lo_len = 0; hi_len = 0; chg_off = -1; chg_cnt = 0; smp_off = -1; smp_cnt = 0;
    while (scl_drive_low && lo_len < 5000) begin
      if (strobe_change) begin chg_cnt++; chg_off = lo_len; end
      if (strobe_sample) smp_cnt += 100;
      lo_len++;
      step();
    end
    while (hi_len < 5000) begin
      if (strobe_sample) begin smp_cnt++; smp_off = hi_len; end
      if (strobe_change) chg_cnt += 100;
      @(negedge clk);
      hi_len++;
      if (hi_len == st_at) ext_low = 1'b1;
      if (hi_len == st_at + st_len) ext_low = 1'b0;
      #1;
      if (scl_drive_low) break;
    end
    ext_low = 1'b0;
  endtask

  task automatic stop_run();
    run = 1'b0;
    step(); step();
  endtask

  task automatic t_reset();
    chk("R1", "drive in reset", scl_drive_low, 0);
    chk("R1", "change strobe in reset", strobe_change, 0);
    chk("R1", "sample strobe in reset", strobe_sample, 0);
  endtask

  task automatic t_period(input string req, input int b, input int hi, input int lo);
    int ll, hl, co, cc, so, sc;
    cfg_word = mk_cfg(b, hi, lo) | 32'hFF000FF0;  // R3 other bits ignored
    run = 1'b1;
    wait_rise();
    measure_cur(0, 0, ll, hl, co, cc, so, sc);
    chk(req, "low length", ll, (lo + 1) << b);
    chk(req, "high length", hl, (hi + 1) << b);
    chk("R5", "change offset", co, ((lo + 1) >> 1) << b);
    chk("R5", "change count", cc, 1);
    chk("R5", "sample offset", so, ((hi + 1) >> 1) << b);
    chk("R5", "sample count", sc, 1);
    stop_run();
  endtask

  task automatic t_cfg_change();
    int ll, hl, co, cc, so, sc;
    cfg_word = mk_cfg(0, 2, 3);
    run = 1'b1;
    wait_rise();
    cfg_word = mk_cfg(1, 3, 0);
    measure_cur(0, 0, ll, hl, co, cc, so, sc);
    chk("R7", "old low kept", ll, 4);
    chk("R7", "old high kept", hl, 3);
    measure_cur(0, 0, ll, hl, co, cc, so, sc);
    chk("R7", "new low", ll, 2);
    chk("R7", "new high", hl, 8);
    stop_run();
  endtask

  task automatic t_stretch(input int b, input int hi, input int lo, input int at, input int len,
                           input int exp_so);
    int ll, hl, co, cc, so, sc;
    cfg_word = mk_cfg(b, hi, lo);
    run = 1'b1;
    wait_rise();
    measure_cur(at, len, ll, hl, co, cc, so, sc);
    chk("R6", "stretched high length", hl, ((hi + 1) << b) + len);
    chk("R6", "delayed sample offset", so, exp_so);
    chk("R6", "single sample strobe", sc, 1);
    chk("R6", "low unaffected", ll, (lo + 1) << b);
    stop_run();
  endtask

  task automatic t_run_drop();
    int bad = 0;
    cfg_word = mk_cfg(0, 7, 7);
    run = 1'b1;
    wait_rise();
    step(); step();
    run = 1'b0;
    for (int i = 0; i < 6; i++) begin
      step();
      if (scl_drive_low || strobe_change || strobe_sample) bad++;
    end
    chk("R2", "released after run drop in low", bad, 0);
    run = 1'b1;
    step();
    chk("R2", "restart in low phase", scl_drive_low, 1);
    while (scl_drive_low) step();
    step();
    run = 1'b0;
    bad = 0;
    for (int i = 0; i < 4; i++) begin
      step();
      if (scl_drive_low || strobe_change || strobe_sample) bad++;
    end
    chk("R2", "released after run drop in high", bad, 0);
  endtask

  task automatic t_freeze();
    int ll = 1, cc = 0, bad = 0;
    cfg_word = mk_cfg(0, 3, 7);
    run = 1'b1;
    wait_rise();
    step(); ll++;
    // sample at index 2: freeze from here
    enable = 1'b0;
    for (int i = 0; i < 5; i++) begin
      step();
      if (!scl_drive_low || strobe_change || strobe_sample) bad++;
      ll++;
    end
    enable = 1'b1;
    while (scl_drive_low && ll < 100) begin
      if (strobe_change) cc++;
      step();
      if (scl_drive_low) ll++;
    end
    chk("R8", "frozen outputs", bad, 0);
    chk("R8", "low length with freeze", ll, 13);
    chk("R8", "change strobe after resume", cc, 1);
    stop_run();
  endtask

  function automatic logic [CFG_W-1:0] enc_model(input int d);
    int b = 0, q, h, l, hf, lf;
    if (d > 33) begin
      q = (d - 1) / 32;
      b = 0;
      while (q > 1) begin q = q / 2; b++; end
      b = b + 1;
    end
    q  = d / (1 << b);
    h  = q / 2 + q % 2;
    l  = q - h;
    hf = (h == 0) ? 0 : ((h - 1 > 15) ? 15 : h - 1);
    lf = (l == 0) ? 0 : ((l - 1 > 15) ? 15 : l - 1);
    return mk_cfg(b, hf, lf);
  endfunction

  task automatic t_encoder();
    int pts[12] = '{0, 1, 2, 17, 33, 34, 64, 100, 250, 1000, 4097, 65535};
    div_req = 16'd33; #1;
    chk("R9", "div 33 word", div_cfg, mk_cfg(0, 15, 15));
    div_req = 16'd34; #1;
    chk("R9", "div 34 word", div_cfg, mk_cfg(1, 8, 7));
    div_req = 16'd100; #1;
    chk("R10", "div 100 word", div_cfg, mk_cfg(2, 12, 11));
    div_req = 16'd250; #1;
    chk("R10", "div 250 word", div_cfg, mk_cfg(3, 15, 14));
    div_req = 16'd1; #1;
    chk("R10", "div 1 word", div_cfg, mk_cfg(0, 0, 0));
    foreach (pts[i]) begin
      div_req = DIV_W'(pts[i]); #1;
      chk("R10", $sformatf("div %0d word", pts[i]), div_cfg, enc_model(pts[i]));
    end
  endtask

  initial begin
    #(HALF * 2 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    enable   = 1'b1;
    run      = 1'b0;
    cfg_word = '0;
    ext_low  = 1'b0;
    div_req  = '0;
    step(); step();
    t_reset();
    step();
    rst_n = 1'b1;
    step();
    t_period("R4", 0, 0, 0);
    t_period("R4", 2, 0, 0);
    t_period("R3", 0, 4, 2);
    t_period("R3", 2, 3, 5);
    t_period("R3", 1, 15, 15);
    t_period("R3", 4, 1, 0);
    t_cfg_change();
    t_stretch(0, 5, 3, 3, 4, 7);
    t_stretch(1, 3, 3, 1, 6, 10);
    t_run_drop();
    t_freeze();
    t_encoder();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule